// File: doc/BRIEF.md
# Batch-Scoped Vertex Reuse Unit

This unit sits between an index fetcher and a vertex shading array. It takes a stream of vertex indices and removes repeated indices within a bounded window called a batch. Each accepted index gets a result beat that carries two things. The first is a local slot number, which tells the assembly stage where the shaded vertex lives. The second is a hit flag, which says whether the vertex was already requested in the current batch. When an index is new to the batch, the unit also issues a shading request on a separate stream. That request carries the global index and the slot it was given.

Reuse memory belongs to one batch only and is never shared across batches. A batch closes in one of two cases. The first is when it has taken `BATCH_LEN` indices. The second is when a new vertex arrives while `UNIQ_MAX` distinct vertices already live in the batch. When a batch closes, every stored index is forgotten. As a result, an index that repeats across a boundary is shaded again. Both parameters are free. For example, `UNIQ_MAX = BATCH_LEN = 384` is a valid setting.

Top module: `vtx_batch_reuse`

## Requirements
- R1: An index already present in the current batch gives `out_hit=1` and the slot assigned at its first appearance, and raises no shading request.
- R2: An index new to the batch gives `out_hit=0` and a slot equal to the number of distinct vertices seen before it in the batch (slots count from 0 in first-appearance order). A request carrying that index and slot fires in the same cycle as the result beat.
- R3: The beat that brings a batch to `BATCH_LEN` accepted indices carries `out_last=1`. The following beat carries a batch identifier one higher (modulo 2^`BID_W`).
- R4: The first index of a new batch is always a miss in slot 0, even if it was present in the previous batch.
- R5: A batch holds at most `UNIQ_MAX` distinct vertices. Hits are still accepted in a full batch. A new index arriving while the batch is full starts the next batch, with a batch identifier one higher, as its slot-0 miss.
- R6: The repeating pattern 0,1,2,… over 96 indices causes exactly 3 shading requests. Over 99 indices it causes exactly 6 (with default parameters).
- R7: A miss is not accepted while `req_ready=0`, and no beat is consumed. A hit is accepted while `out_ready=1`, whatever the value of `req_ready`.
- R8: While `out_ready=0`, no index is accepted and no request is raised.
- R9: After reset the batch identifier is 0, the first index takes slot 0, and with `in_valid=0` neither output stream is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Index beat valid |
| in_ready | output | 1 | Index beat accepted when high with in_valid |
| in_index | input | IDX_W | Global vertex index |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Result consumer ready |
| out_slot | output | SLOT_W | Batch-local slot of the vertex |
| out_hit | output | 1 | Vertex already requested in this batch |
| out_batch | output | BID_W | Batch identifier |
| out_last | output | 1 | Beat fills the batch to BATCH_LEN |
| req_valid | output | 1 | Shading request valid |
| req_ready | input | 1 | Shading array ready |
| req_index | output | IDX_W | Global index to shade |
| req_slot | output | SLOT_W | Slot that receives the shaded result |

## Verification
A stale valid bit left over after a boundary shows up as a hit on the first beat of the next batch. An index count that is off by one moves `out_last` and the batch identifier change one beat away from the 96th index. Both errors show up within one batch of stimulus. A wrong slot encoding, or an allocation pointer that skips, appears on the very next hit, because that hit returns a slot different from the one its miss reported. A flaw in the handshake shows up in the same cycle as the stall, either as a consumed index or as a request without a paired result beat.

// File: rtl/vrb_pkg.sv
package vrb_pkg;

    // Per-beat classification produced by the lookup stage.
    typedef struct packed {
        logic hit;      // index found in the live batch
        logic restart;  // new index met a full batch: open a fresh one first
        logic close;    // this beat brings the batch to its index limit
    } vrb_decision_t;

endpackage

// File: rtl/vrb_tag_match.sv
module vrb_tag_match #(
    parameter int IDX_W   = 32,
    parameter int ENTRIES = 32,
    parameter int SLOT_W  = 5
) (
    input  logic [ENTRIES-1:0][IDX_W-1:0] tags,
    input  logic [ENTRIES-1:0]            vld,
    input  logic [IDX_W-1:0]              key,
    output logic                          hit,
    output logic [SLOT_W-1:0]             slot
);

    logic [ENTRIES-1:0] match;

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = vld[g] && (tags[g] == key);
    end

    // Entries never hold the same index twice, so an OR-encode is exact.
    always_comb begin
        slot = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                slot = slot | SLOT_W'(i);
            end
        end
        hit = |match;
    end

endmodule

// File: rtl/vrb_flow.sv
module vrb_flow (
    input  logic in_valid,
    input  logic hit,
    input  logic out_ready,
    input  logic req_ready,
    output logic in_ready,
    output logic out_valid,
    output logic req_valid,
    output logic accept
);

    // A miss needs both downstream streams; a hit needs only the result stream.
    always_comb begin
        in_ready  = out_ready && (hit || req_ready);
        out_valid = in_valid && (hit || req_ready);
        req_valid = in_valid && !hit && out_ready;
        accept    = in_valid && in_ready;
    end

endmodule

// File: rtl/vtx_batch_reuse.sv
module vtx_batch_reuse #(
    parameter int IDX_W     = 32,
    parameter int BATCH_LEN = 96,
    parameter int UNIQ_MAX  = 32,
    parameter int BID_W     = 8,
    localparam int SLOT_W   = (UNIQ_MAX > 1) ? $clog2(UNIQ_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SLOT_W-1:0] out_slot,
    output logic              out_hit,
    output logic [BID_W-1:0]  out_batch,
    output logic              out_last,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [IDX_W-1:0]  req_index,
    output logic [SLOT_W-1:0] req_slot
);
    import vrb_pkg::*;

    localparam int CNT_W  = $clog2(BATCH_LEN + 1);
    localparam int UCNT_W = $clog2(UNIQ_MAX + 1);

    typedef struct packed {
        logic [UNIQ_MAX-1:0]            vld;
        logic [UNIQ_MAX-1:0][IDX_W-1:0] tag;
        logic [CNT_W-1:0]               cnt;
        logic [UCNT_W-1:0]              uniq;
        logic [BID_W-1:0]               bid;
    } state_t;

    state_t        s_q, s_d;
    vrb_decision_t dec;
    logic          match_hit;
    logic [SLOT_W-1:0] match_slot;
    logic          accept;
    logic [CNT_W-1:0]  base_cnt;
    logic [UCNT_W-1:0] base_uniq;
    logic [BID_W-1:0]  cur_bid;
    logic [SLOT_W-1:0] slot_sel;

    vrb_tag_match #(
        .IDX_W   (IDX_W),
        .ENTRIES (UNIQ_MAX),
        .SLOT_W  (SLOT_W)
    ) u_match (
        .tags (s_q.tag),
        .vld  (s_q.vld),
        .key  (in_index),
        .hit  (match_hit),
        .slot (match_slot)
    );

    vrb_flow u_flow (
        .in_valid  (in_valid),
        .hit       (match_hit),
        .out_ready (out_ready),
        .req_ready (req_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .req_valid (req_valid),
        .accept    (accept)
    );

    always_comb begin
        dec.hit     = match_hit;
        dec.restart = !match_hit && (s_q.uniq == UCNT_W'(UNIQ_MAX));
        base_cnt    = dec.restart ? '0 : s_q.cnt;
        base_uniq   = dec.restart ? '0 : s_q.uniq;
        cur_bid     = dec.restart ? s_q.bid + BID_W'(1) : s_q.bid;
        dec.close   = (base_cnt == CNT_W'(BATCH_LEN - 1));
        slot_sel    = dec.hit ? match_slot : base_uniq[SLOT_W-1:0];

        out_slot  = slot_sel;
        out_hit   = dec.hit;
        out_batch = cur_bid;
        out_last  = dec.close;
        req_index = in_index;
        req_slot  = slot_sel;

        s_d = s_q;
        if (accept) begin
            if (dec.restart) begin
                s_d.vld = '0;
            end
            if (!dec.hit) begin
                s_d.vld[slot_sel] = 1'b1;
                s_d.tag[slot_sel] = in_index;
                s_d.uniq          = base_uniq + UCNT_W'(1);
            end else begin
                s_d.uniq = base_uniq;
            end
            s_d.cnt = base_cnt + CNT_W'(1);
            s_d.bid = cur_bid;
            if (dec.close) begin
                s_d.vld  = '0;
                s_d.cnt  = '0;
                s_d.uniq = '0;
                s_d.bid  = cur_bid + BID_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.vld  <= '0;
            s_q.tag  <= '0;
            s_q.cnt  <= '0;
            s_q.uniq <= '0;
            s_q.bid  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/vrb_checker.sv
module vrb_checker #(
    parameter int IDX_W     = 32,
    parameter int BATCH_LEN = 96,
    parameter int UNIQ_MAX  = 32,
    parameter int BID_W     = 8,
    parameter int SLOT_W    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SLOT_W-1:0] out_slot,
    input logic              out_hit,
    input logic [BID_W-1:0]  out_batch,
    input logic              out_last,
    input logic              req_valid,
    input logic              req_ready,
    input logic [SLOT_W-1:0] req_slot
);

    logic             acc;
    logic             prev_last_q;
    logic [BID_W-1:0] last_bid_q;
    logic [BID_W-1:0] cur_bid_q;
    int               beat_cnt_q;
    int               miss_cnt_q;

    assign acc = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_last_q <= 1'b0;
            last_bid_q  <= '0;
            cur_bid_q   <= '0;
            beat_cnt_q  <= 0;
            miss_cnt_q  <= 0;
        end else if (acc) begin
            prev_last_q <= out_last;
            last_bid_q  <= out_batch;
            cur_bid_q   <= out_batch;
            if (out_batch != cur_bid_q) begin
                beat_cnt_q <= 1;
                miss_cnt_q <= out_hit ? 0 : 1;
            end else begin
                beat_cnt_q <= beat_cnt_q + 1;
                miss_cnt_q <= miss_cnt_q + (out_hit ? 0 : 1);
            end
        end
    end

    assert_hit_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_hit) |-> !req_valid);

    assert_req_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (out_valid && out_ready && !out_hit && req_slot == out_slot));

    assert_batch_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_cnt_q <= BATCH_LEN);

    assert_fresh_batch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && prev_last_q) |-> (!out_hit && out_slot == '0 && out_batch == last_bid_q + BID_W'(1)));

    assert_uniq_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        miss_cnt_q <= UNIQ_MAX);

    assert_miss_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_hit && !req_ready) |-> !in_ready);

    assert_out_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |-> (!in_ready && !req_valid));

endmodule

bind vtx_batch_reuse vrb_checker #(
    .IDX_W     (IDX_W),
    .BATCH_LEN (BATCH_LEN),
    .UNIQ_MAX  (UNIQ_MAX),
    .BID_W     (BID_W),
    .SLOT_W    (SLOT_W)
) u_vrb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_slot  (out_slot),
    .out_hit   (out_hit),
    .out_batch (out_batch),
    .out_last  (out_last),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_slot  (req_slot)
);

// File: tb/tb_vtx_batch_reuse.sv
module tb_vtx_batch_reuse;

    localparam int IDX_W = 32;
    localparam int SLOT_W = 5;
    localparam int BID_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [IDX_W-1:0]  in_index = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [SLOT_W-1:0] out_slot;
    logic              out_hit;
    logic [BID_W-1:0]  out_batch;
    logic              out_last;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [IDX_W-1:0]  req_index;
    logic [SLOT_W-1:0] req_slot;

    int checks = 0;
    int errors = 0;
    int nreq   = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    vtx_batch_reuse dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_index  (in_index),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_slot  (out_slot),
        .out_hit   (out_hit),
        .out_batch (out_batch),
        .out_last  (out_last),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_index (req_index),
        .req_slot  (req_slot)
    );

    task automatic chk(input bit ok, input string rq, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", rq, msg);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; req_ready = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one index with both consumers ready; check the beat, then let it pass.
    task automatic send(input int idx, input bit eh, input int es, input int eb,
                        input bit el, input string rq);
        @(negedge clk);
        in_valid = 1'b1; in_index = idx;
        #1;
        chk(out_valid === 1'b1 && in_ready === 1'b1 && out_hit === eh &&
            out_slot === SLOT_W'(es) && out_batch === BID_W'(eb) && out_last === el &&
            req_valid === !eh && (eh || (req_index === IDX_W'(idx) && req_slot === SLOT_W'(es))),
            rq, $sformatf("idx %0d act hit=%0b slot=%0d batch=%0d last=%0d req=%0b exp hit=%0b slot=%0d batch=%0d last=%0b",
                          idx, out_hit, out_slot, out_batch, out_last, req_valid, eh, es, eb, el));
        if (req_valid && req_ready) nreq++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk); #1;
        chk(out_valid === 1'b0 && req_valid === 1'b0, "R9",
            $sformatf("idle act out_valid=%0b req_valid=%0b exp 0 0", out_valid, req_valid));
        send(55, 1'b0, 0, 0, 1'b0, "R9");
    endtask

    task automatic t_basic();
        do_reset();
        send(10, 1'b0, 0, 0, 1'b0, "R2");
        send(20, 1'b0, 1, 0, 1'b0, "R2");
        send(10, 1'b1, 0, 0, 1'b0, "R1");
        send(30, 1'b0, 2, 0, 1'b0, "R2");
        send(20, 1'b1, 1, 0, 1'b0, "R1");
        send(30, 1'b1, 2, 0, 1'b0, "R1");
    endtask

    task automatic t_pattern();
        do_reset();
        nreq = 0;
        for (int i = 0; i < 96; i++)
            send(i % 3, (i >= 3), i % 3, 0, (i == 95), "R3");
        chk(nreq == 3, "R6", $sformatf("requests after 96 act %0d exp 3", nreq));
        for (int i = 96; i < 99; i++)
            send(i % 3, 1'b0, i % 3, 1, 1'b0, "R4");
        chk(nreq == 6, "R6", $sformatf("requests after 99 act %0d exp 6", nreq));
    endtask

    task automatic t_uniques();
        do_reset();
        for (int i = 0; i < 32; i++)
            send(1000 + i, 1'b0, i, 0, 1'b0, "R5");
        send(1005, 1'b1, 5, 0, 1'b0, "R5");
        send(1031, 1'b1, 31, 0, 1'b0, "R5");
        send(7777, 1'b0, 0, 1, 1'b0, "R5");
        send(1005, 1'b0, 1, 1, 1'b0, "R4");
    endtask

    task automatic t_req_stall();
        do_reset();
        @(negedge clk);
        req_ready = 1'b0; in_valid = 1'b1; in_index = 7;
        #1;
        chk(in_ready === 1'b0 && out_valid === 1'b0, "R7",
            $sformatf("miss stall act in_ready=%0b out_valid=%0b exp 0 0", in_ready, out_valid));
        @(posedge clk); #1;
        in_valid = 1'b0; req_ready = 1'b1;
        send(7, 1'b0, 0, 0, 1'b0, "R7");
        @(negedge clk);
        req_ready = 1'b0; in_valid = 1'b1; in_index = 7;
        #1;
        chk(in_ready === 1'b1 && out_valid === 1'b1 && out_hit === 1'b1, "R7",
            $sformatf("hit under stall act in_ready=%0b out_valid=%0b hit=%0b exp 1 1 1",
                      in_ready, out_valid, out_hit));
        @(posedge clk); #1;
        in_valid = 1'b0; req_ready = 1'b1;
    endtask

    task automatic t_out_stall();
        do_reset();
        send(7, 1'b0, 0, 0, 1'b0, "R8");
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_index = 8;
        #1;
        chk(in_ready === 1'b0 && req_valid === 1'b0, "R8",
            $sformatf("out stall act in_ready=%0b req_valid=%0b exp 0 0", in_ready, req_valid));
        @(posedge clk); #1;
        in_valid = 1'b0; out_ready = 1'b1;
        send(8, 1'b0, 1, 0, 1'b0, "R8");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_pattern();
        t_uniques();
        t_req_stall();
        t_out_stall();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: act timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule